// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the register-write front end of an eight-input interrupt controller. It watches byte writes aimed at the controller's two I/O ports: the even base port and the odd port at base+1. A write to the base port with data bit 4 set always begins a fixed four-byte initialization sequence. The sequence then takes three more bytes on base+1 in order. Starting a sequence applies a set of automatic resets to the operating state. Completing it presents the captured configuration to the controller core.

Once initialization is complete, base+1 writes load the interrupt mask. Base-port writes with bit 4 clear are passed on to the core as operation commands. Part of that command traffic is decoded here as well: the special-mask-mode and status-read selection, and an explicit lowest-priority setting. A parameter selects between the master and the slave variant. The two differ only in how the third byte is kept and in the reset value of the cascade field.

Top module: `irq_init_sequencer`

## Requirements
- R1: After reset, init_done is 0, irq_mask is 00h, spec_mask and read_isr are 0, lowest_prio is 7, vec_base and mode_bits are 0, and casc_cfg is 00h on a master or 07h on a slave.
- R2: A write to BASE_ADDR with data bit 4 = 1 starts initialization in any state. In the next cycle init_done is 0, rearm_pulse is 1 for that one cycle (the core must then see a low-to-high edge on each input), and level_trig equals data bit 3.
- R3: Starting initialization clears irq_mask, sets spec_mask to 0, sets read_isr to 0 (status reads return the request register), and sets lowest_prio to 7.
- R4: Starting initialization sets casc_cfg to 07h on a slave (cascade identity 7) and to 00h on a master.
- R5: The next three writes to BASE_ADDR+1 are taken in order. The first loads vec_base from data bits 7:3. The second loads casc_cfg. The third loads mode_bits from data bits 4:0 and raises init_done.
- R6: On a slave, the second of those bytes sets casc_cfg to {5'b0, data[2:0]}. On a master, it loads the whole byte.
- R7: While init_done is 1, a write to BASE_ADDR+1 loads irq_mask with the data. Before initialization completes, such writes do not change irq_mask unless they are sequence bytes.
- R8: While init_done is 1, a write to BASE_ADDR with bit 4 = 0 gives ocw_valid = 1 for exactly one cycle, with ocw_data equal to the byte. Such writes have no effect and produce no ocw_valid while init_done is 0.
- R9: An operation command with bit 3 = 1 updates spec_mask from bit 5 when bit 6 is 1. It updates read_isr from bit 0 when bit 1 is 1.
- R10: An operation command with bit 3 = 0 and bits 7:5 = 110b sets lowest_prio to bits 2:0. Other such commands leave lowest_prio unchanged.
- R11: A new start write in the middle of a sequence restarts it, so the next BASE_ADDR+1 write loads vec_base again.
- R12: Writes with wr_en low, or to any address other than BASE_ADDR and BASE_ADDR+1, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | NUM_IRQ | Write data byte |
| init_done | output | 1 | Initialization sequence complete |
| rearm_pulse | output | 1 | One-cycle pulse: inputs must see a fresh rising edge |
| level_trig | output | 1 | Level-triggered input mode selected |
| vec_base | output | NUM_IRQ-3 | Upper bits of the interrupt vector |
| casc_cfg | output | NUM_IRQ | Cascade map (master) or cascade identity (slave) |
| mode_bits | output | MODE_W | Mode field from the fourth byte |
| irq_mask | output | NUM_IRQ | Interrupt mask register |
| spec_mask | output | 1 | Special mask mode enabled |
| read_isr | output | 1 | Status reads return the in-service register |
| lowest_prio | output | 3 | Input that currently has lowest priority |
| ocw_valid | output | 1 | Operation command strobe to the core |
| ocw_data | output | NUM_IRQ | Operation command byte |

## Verification
The hardest case to reach from the ports is a sequence cut short. A fresh start byte arrives after the vector byte has already been taken, while the sequence is still mid-way. Base-port bytes with bit 4 clear are also slipped in during the sequence; they must not reach the core or touch the command state. The stimulus drives a full sequence, then starts a second one and interrupts it after its second byte. It then checks that the following base+1 byte is treated as the vector byte again and that the cascade field went back to its start value. A scoreboard queue holds the command bytes that should reach the core. Any strobe with no matching entry is reported.

// File: rtl/irq_init_pkg.sv
package irq_init_pkg;

   typedef enum logic [2:0] {
      SEQ_UNINIT = 3'd0,
      SEQ_W2     = 3'd1,
      SEQ_W3     = 3'd2,
      SEQ_W4     = 3'd3,
      SEQ_RUN    = 3'd4
   } seq_state_t;

   typedef struct packed {
      logic start;   // base port, bit 4 set
      logic opcmd;   // base port, bit 4 clear
      logic port1;   // base+1 port
   } wr_kind_t;

   // bit positions inside the written byte
   localparam int unsigned START_BIT    = 4;
   localparam int unsigned LEVEL_BIT    = 3;
   localparam int unsigned OC_SEL_BIT   = 3;
   localparam int unsigned OC_ESM_BIT   = 6;
   localparam int unsigned OC_SM_BIT    = 5;
   localparam int unsigned OC_RR_BIT    = 1;
   localparam int unsigned OC_RIS_BIT   = 0;
   localparam logic [2:0]  OC_SETPRIO   = 3'b110;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
   import irq_init_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output wr_kind_t          kind
);

   localparam logic [ADDR_W-1:0] PORT1_ADDR = BASE_ADDR | ADDR_W'(1);

   generate
      if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
         $error("irq_wr_decode: BASE_ADDR must be even");
      end
      if (DATA_W <= START_BIT) begin : g_bad_width
         $error("irq_wr_decode: DATA_W too narrow");
      end
   endgenerate

   logic hit_base;
   logic hit_port1;

   always_comb begin
      hit_base   = wr_en && (wr_addr == BASE_ADDR);
      hit_port1  = wr_en && (wr_addr == PORT1_ADDR);
      kind.start = hit_base &&  wr_data[START_BIT];
      kind.opcmd = hit_base && !wr_data[START_BIT];
      kind.port1 = hit_port1;
   end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_init_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  wr_kind_t   kind,
   output seq_state_t state,
   output logic       load_w2,
   output logic       load_w3,
   output logic       load_w4,
   output logic       running
);

   seq_state_t state_nx;

   always_comb begin
      state_nx = state;
      if (kind.start) begin
         state_nx = SEQ_W2;
      end else if (kind.port1) begin
         case (state)
            SEQ_W2:  state_nx = SEQ_W3;
            SEQ_W3:  state_nx = SEQ_W4;
            SEQ_W4:  state_nx = SEQ_RUN;
            default: state_nx = state;
         endcase
      end
   end

   always_comb begin
      load_w2 = !kind.start && kind.port1 && (state == SEQ_W2);
      load_w3 = !kind.start && kind.port1 && (state == SEQ_W3);
      load_w4 = !kind.start && kind.port1 && (state == SEQ_W4);
      running = (state == SEQ_RUN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_UNINIT;
      else        state <= state_nx;
   end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_init_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned VEC_W    = 5,
   parameter int unsigned ID_W     = 3,
   parameter int unsigned MODE_W   = 5,
   parameter bit          IS_SLAVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              load_w2,
   input  logic              load_w3,
   input  logic              load_w4,
   input  logic [DATA_W-1:0] wr_data,
   output logic              level_trig,
   output logic              rearm_pulse,
   output logic [VEC_W-1:0]  vec_base,
   output logic [DATA_W-1:0] casc_cfg,
   output logic [MODE_W-1:0] mode_bits
);

   generate
      if (VEC_W + ID_W != DATA_W) begin : g_bad_vec
         $error("irq_cfg_regs: VEC_W + ID_W must equal DATA_W");
      end
      if (MODE_W > DATA_W) begin : g_bad_mode
         $error("irq_cfg_regs: MODE_W wider than DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_trig  <= 1'b0;
         rearm_pulse <= 1'b0;
         vec_base    <= '0;
         mode_bits   <= '0;
      end else begin
         rearm_pulse <= start;
         if (start)   level_trig <= wr_data[LEVEL_BIT];
         if (load_w2) vec_base   <= wr_data[DATA_W-1 -: VEC_W];
         if (load_w4) mode_bits  <= wr_data[MODE_W-1:0];
      end
   end

   generate
      if (IS_SLAVE) begin : g_slave
         localparam logic [ID_W-1:0] ID_RST = '1;
         logic [ID_W-1:0] slave_id;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slave_id <= ID_RST;
            else if (start)   slave_id <= ID_RST;
            else if (load_w3) slave_id <= wr_data[ID_W-1:0];
         end
         assign casc_cfg = {{(DATA_W-ID_W){1'b0}}, slave_id};
      end else begin : g_master
         logic [DATA_W-1:0] slave_map;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slave_map <= '0;
            else if (start)   slave_map <= '0;
            else if (load_w3) slave_map <= wr_data;
         end
         assign casc_cfg = slave_map;
      end
   endgenerate

endmodule

// File: rtl/irq_op_regs.sv
module irq_op_regs
   import irq_init_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_t          kind,
   input  logic              running,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] irq_mask,
   output logic              spec_mask,
   output logic              read_isr,
   output logic [PRIO_W-1:0] lowest_prio,
   output logic              ocw_valid,
   output logic [DATA_W-1:0] ocw_data
);

   localparam logic [PRIO_W-1:0] PRIO_RST = '1;

   logic cmd_live;
   logic is_sel3;
   logic set_prio;

   always_comb begin
      cmd_live = running && kind.opcmd;
      is_sel3  = wr_data[OC_SEL_BIT];
      set_prio = cmd_live && !is_sel3 && (wr_data[DATA_W-1 -: 3] == OC_SETPRIO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_mask    <= '0;
         spec_mask   <= 1'b0;
         read_isr    <= 1'b0;
         lowest_prio <= PRIO_RST;
         ocw_valid   <= 1'b0;
         ocw_data    <= '0;
      end else begin
         ocw_valid <= cmd_live;
         if (cmd_live) ocw_data <= wr_data;
         if (kind.start) begin
            irq_mask    <= '0;
            spec_mask   <= 1'b0;
            read_isr    <= 1'b0;
            lowest_prio <= PRIO_RST;
         end else begin
            if (running && kind.port1) irq_mask <= wr_data;
            if (cmd_live && is_sel3 && wr_data[OC_ESM_BIT]) spec_mask <= wr_data[OC_SM_BIT];
            if (cmd_live && is_sel3 && wr_data[OC_RR_BIT])  read_isr  <= wr_data[OC_RIS_BIT];
            if (set_prio) lowest_prio <= wr_data[PRIO_W-1:0];
         end
      end
   end

endmodule

// File: rtl/irq_init_sequencer.sv
module irq_init_sequencer
   import irq_init_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_IRQ   = 8,
   parameter int unsigned MODE_W    = 5,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
   parameter bit          IS_SLAVE  = 1'b0,
   localparam int unsigned PRIO_W   = $clog2(NUM_IRQ),
   localparam int unsigned VEC_W    = NUM_IRQ - PRIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [NUM_IRQ-1:0] wr_data,
   output logic               init_done,
   output logic               rearm_pulse,
   output logic               level_trig,
   output logic [VEC_W-1:0]   vec_base,
   output logic [NUM_IRQ-1:0] casc_cfg,
   output logic [MODE_W-1:0]  mode_bits,
   output logic [NUM_IRQ-1:0] irq_mask,
   output logic               spec_mask,
   output logic               read_isr,
   output logic [PRIO_W-1:0]  lowest_prio,
   output logic               ocw_valid,
   output logic [NUM_IRQ-1:0] ocw_data
);

   generate
      if (NUM_IRQ != 8) begin : g_bad_irq
         $error("irq_init_sequencer: byte-wide command set needs NUM_IRQ == 8");
      end
   endgenerate

   wr_kind_t   kind;
   seq_state_t state;
   logic       load_w2, load_w3, load_w4, running;

   irq_wr_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (NUM_IRQ),
      .BASE_ADDR(BASE_ADDR)
   ) i_decode (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .kind   (kind)
   );

   irq_seq_fsm i_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind   (kind),
      .state  (state),
      .load_w2(load_w2),
      .load_w3(load_w3),
      .load_w4(load_w4),
      .running(running)
   );

   irq_cfg_regs #(
      .DATA_W  (NUM_IRQ),
      .VEC_W   (VEC_W),
      .ID_W    (PRIO_W),
      .MODE_W  (MODE_W),
      .IS_SLAVE(IS_SLAVE)
   ) i_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (kind.start),
      .load_w2    (load_w2),
      .load_w3    (load_w3),
      .load_w4    (load_w4),
      .wr_data    (wr_data),
      .level_trig (level_trig),
      .rearm_pulse(rearm_pulse),
      .vec_base   (vec_base),
      .casc_cfg   (casc_cfg),
      .mode_bits  (mode_bits)
   );

   irq_op_regs #(
      .DATA_W(NUM_IRQ),
      .PRIO_W(PRIO_W)
   ) i_op (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .running    (running),
      .wr_data    (wr_data),
      .irq_mask   (irq_mask),
      .spec_mask  (spec_mask),
      .read_isr   (read_isr),
      .lowest_prio(lowest_prio),
      .ocw_valid  (ocw_valid),
      .ocw_data   (ocw_data)
   );

   assign init_done = running;

endmodule

// File: rtl/irq_init_sequencer_chk.sv
module irq_init_sequencer_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_IRQ   = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
   parameter int unsigned PRIO_W    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [NUM_IRQ-1:0] wr_data,
   input logic               init_done,
   input logic               rearm_pulse,
   input logic [NUM_IRQ-1:0] irq_mask,
   input logic               spec_mask,
   input logic               read_isr,
   input logic [PRIO_W-1:0]  lowest_prio,
   input logic               ocw_valid
);

   logic seen_q;
   logic start_hit;
   logic port1_hit;

   assign start_hit = wr_en && (wr_addr == BASE_ADDR) && wr_data[4];
   assign port1_hit = wr_en && (wr_addr == (BASE_ADDR | ADDR_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   // R3
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_hit |=> (irq_mask == '0) && !spec_mask && !read_isr &&
                    (lowest_prio == '1) && !init_done);

   // R2
   rearm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && rearm_pulse) |-> $past(start_hit));

   // R8
   ocw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && ocw_valid) |-> $past(init_done));

   // R7
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !$past(init_done) && !$past(start_hit)) |-> $stable(irq_mask));

   // R5
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $rose(init_done)) |-> $past(port1_hit));

endmodule

bind irq_init_sequencer irq_init_sequencer_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_IRQ  (NUM_IRQ),
   .BASE_ADDR(BASE_ADDR),
   .PRIO_W   (PRIO_W)
) i_chk (.*);

// File: tb/test_irq_init_sequencer.sv
module test_irq_init_sequencer;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n;
   logic       m_wr_en, s_wr_en;
   logic [7:0] m_addr, m_data, s_addr, s_data;

   logic       m_done, m_rearm, m_level, m_smask, m_risr, m_ocwv;
   logic [4:0] m_vec, m_mode;
   logic [7:0] m_casc, m_mask, m_ocwd;
   logic [2:0] m_prio;

   logic       s_done, s_rearm, s_level, s_smask, s_risr, s_ocwv;
   logic [4:0] s_vec, s_mode;
   logic [7:0] s_casc, s_mask, s_ocwd;
   logic [2:0] s_prio;

   irq_init_sequencer i_irq_init_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_en(m_wr_en), .wr_addr(m_addr), .wr_data(m_data),
      .init_done(m_done), .rearm_pulse(m_rearm), .level_trig(m_level),
      .vec_base(m_vec), .casc_cfg(m_casc), .mode_bits(m_mode), .irq_mask(m_mask),
      .spec_mask(m_smask), .read_isr(m_risr), .lowest_prio(m_prio),
      .ocw_valid(m_ocwv), .ocw_data(m_ocwd));

   irq_init_sequencer #(.BASE_ADDR(8'hA0), .IS_SLAVE(1'b1)) i_irq_init_sequencer_slv (
      .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_addr(s_addr), .wr_data(s_data),
      .init_done(s_done), .rearm_pulse(s_rearm), .level_trig(s_level),
      .vec_base(s_vec), .casc_cfg(s_casc), .mode_bits(s_mode), .irq_mask(s_mask),
      .spec_mask(s_smask), .read_isr(s_risr), .lowest_prio(s_prio),
      .ocw_valid(s_ocwv), .ocw_data(s_ocwd));

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int m_seq = 0;         // bench model: 4 means sequence complete
   logic [7:0] exp_q[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: one write to the master, expected command bytes pushed to the scoreboard
   task automatic mwr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      m_wr_en = 1'b1; m_addr = a; m_data = d;
      if (a == 8'h20 && d[4]) m_seq = 1;
      else if (a == 8'h21 && m_seq >= 1 && m_seq < 4) m_seq++;
      else if (a == 8'h20 && !d[4] && m_seq == 4) exp_q.push_back(d);
      @(negedge clk);
      m_wr_en = 1'b0;
   endtask

   task automatic swr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      s_wr_en = 1'b1; s_addr = a; s_data = d;
      @(negedge clk);
      s_wr_en = 1'b0;
   endtask

   // monitor: compare command strobes with the scoreboard
   always @(negedge clk) begin
      if (rst_n && m_ocwv) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8 unexpected command strobe: actual %0h expected none", m_ocwd);
         end else begin
            check("R8 command byte", m_ocwd, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; m_wr_en = 1'b0; s_wr_en = 1'b0;
      m_addr = '0; m_data = '0; s_addr = '0; s_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 done",  m_done, 0);
      check("R1 mask",  m_mask, 8'h00);
      check("R1 flags", {m_smask, m_risr}, 0);
      check("R1 prio",  m_prio, 7);
      check("R1 vec/mode", {m_vec, m_mode}, 0);
      check("R1 master casc", m_casc, 8'h00);
      check("R1 slave casc",  s_casc, 8'h07);

      // R7 / R8 writes before any sequence are ignored
      mwr(8'h21, 8'h55);
      check("R7 mask before init", m_mask, 8'h00);
      mwr(8'h20, 8'h6B);
      check("R8 flags before init", {m_smask, m_risr}, 0);

      // R2 start
      mwr(8'h20, 8'h18);
      check("R2 rearm pulse", m_rearm, 1);
      check("R2 level mode", m_level, 1);
      check("R2 not done", m_done, 0);
      @(negedge clk);
      check("R2 rearm one cycle", m_rearm, 0);

      // R5 sequence, with a command byte slipped in (R8 ignored)
      mwr(8'h21, 8'h40);
      check("R5 vector base", m_vec, 5'h08);
      mwr(8'h21, 8'h04);
      check("R5 master cascade", m_casc, 8'h04);
      mwr(8'h20, 8'h6A);
      check("R8 ignored mid-sequence", {m_smask, m_risr, m_done}, 0);
      mwr(8'h21, 8'h13);
      check("R5 mode bits", m_mode, 5'h13);
      check("R5 done", m_done, 1);

      // R7 mask load
      mwr(8'h21, 8'hA5);
      check("R7 mask", m_mask, 8'hA5);

      // R9 operation commands of the select-3 form
      mwr(8'h20, 8'h68);
      check("R9 special mask set", m_smask, 1);
      mwr(8'h20, 8'h0B);
      check("R9 read isr", m_risr, 1);
      mwr(8'h20, 8'h28);
      check("R9 special mask unchanged without enable", m_smask, 1);

      // R10 priority
      mwr(8'h20, 8'hC3);
      check("R10 set lowest prio", m_prio, 3);
      mwr(8'h20, 8'h20);
      check("R10 other command keeps prio", m_prio, 3);

      // R12 foreign address and idle strobe
      mwr(8'h22, 8'h11);
      check("R12 foreign address", m_mask, 8'hA5);
      @(negedge clk);
      m_addr = 8'h20; m_data = 8'h10;
      @(negedge clk);
      check("R12 no strobe", {m_done, m_rearm, m_mask}, {1'b1, 1'b0, 8'hA5});

      // R3 restart clears operating state
      mwr(8'h20, 8'h10);
      check("R3 mask cleared", m_mask, 8'h00);
      check("R3 flags cleared", {m_smask, m_risr}, 0);
      check("R3 prio", m_prio, 7);
      check("R4 master casc cleared", m_casc, 8'h00);
      check("R2 edge mode", m_level, 0);

      // R11 restart mid-sequence
      mwr(8'h21, 8'h80);
      check("R11 first vector", m_vec, 5'h10);
      mwr(8'h21, 8'h0F);
      mwr(8'h20, 8'h18);
      check("R11 casc back to start value", m_casc, 8'h00);
      mwr(8'h21, 8'hF8);
      check("R11 vector reloaded", m_vec, 5'h1F);
      mwr(8'h21, 8'h02);
      check("R11 not done early", m_done, 0);
      mwr(8'h21, 8'h01);
      check("R11 done", {m_done, m_casc, m_mode}, {1'b1, 8'h02, 5'h01});

      // R4 / R6 slave variant
      swr(8'hA1, 8'h03);
      swr(8'hA0, 8'h11);
      check("R4 slave id reset", s_casc, 8'h07);
      swr(8'hA1, 8'h70);
      swr(8'hA1, 8'hFA);
      check("R6 slave id", s_casc, 8'h02);
      swr(8'hA1, 8'h01);
      check("R6 slave done", {s_done, s_vec}, {1'b1, 5'h0E});

      repeat (3) @(negedge clk);
      check("R8 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule